// File: doc/BRIEF.md
# Used Ring Completion and Interrupt Gate

This block is the completion side of a split-ring request queue engine. Up to `NUM_QUEUES` queues share one memory port. Each queue keeps its own producer index. A completion command writes one used element into that queue's used ring: a 32-bit head identifier followed by a 32-bit total length. The element goes into the ring slot that equals the producer index modulo the ring size, and then the index advances. The index word that the driver sees in memory does not move on a completion. It moves only when a separate sync command publishes it.

After each sync, the block reads the queue's available-ring flags and decides whether to interrupt the driver. The driver can suppress interrupts with its no-interrupt flag. That suppression is overridden when notify-on-empty was negotiated and the queue has drained. A raised interrupt sets the queue cause bit in a small cause register and asserts a level interrupt line. Reading the cause register clears it and lowers the line. Separate counters record how many interrupts were raised and how many were skipped. A third command sets or clears the no-notify flag in the used ring by a read-modify-write that touches only that flag.

Memory is addressed in 32-bit words. The word at `usedBase` holds the used flags in bits 15:0 and the published index in bits 31:16. Used slot k sits at `usedBase+1+2k` (identifier) and `usedBase+2+2k` (length). The word at `availBase` holds the available flags in bits 15:0. A read returns data on `memRdData` one cycle after `memRdEn`.

Top module: `used_ring_completer`

## Requirements
- R1: After reset, `cmdReady` is 1, `irqLine` is 0, `isrValue` is 0, both counters are 0, and neither `memWrEn` nor `memRdEn` is asserted.
- R2: A completion command (`cmdOp`=1) writes `cmdId` to word `usedBase+1+2*s` and `cmdLen` to word `usedBase+2+2*s`, both with all byte enables set. Here s is the selected queue's producer index modulo 2^`RING_LOG2`. The index then increments. Each queue's index is independent, and slots wrap after the last one.
- R3: A completion leaves the word at `usedBase` untouched. A sync command (`cmdOp`=2) writes the queue's current producer index to bits 31:16 of that word with byte enables 4'b1100, so the flags half is preserved.
- R4: After the sync write, the block reads the word at `availBase`. If bit 0 (no-interrupt) is clear, it sets bit 0 of `isrValue`, drives `irqLine` high and increments `countRaised` by one.
- R5: If bit 0 of the available flags is set and the override of R6 does not apply, no interrupt is raised, `isrValue` and `irqLine` keep their values, and `countSkipped` increments by one.
- R6: If `notifyOnEmpty` is 1 and the `queueEmpty` bit of the synced queue is 1, the interrupt is raised even when the no-interrupt flag is set. The empty bit of any other queue has no effect.
- R7: A notify-control command (`cmdOp`=3) reads the word at `usedBase` and writes back bits 15:0 with byte enables 4'b0011. Bit 0 (no-notify) becomes the inverse of `cmdEnable`, and bits 15:1 keep their values.
- R8: While `isrRdEn` is high, `isrValue` shows the cause register. On that clock edge the register clears and `irqLine` falls, unless an interrupt is raised on the same edge. Only bit 0 is ever set.
- R9: A command with `cmdValid` high while `cmdReady` is low is ignored and changes no memory word and no producer index. An accepted command drops `cmdReady` on the next cycle until it is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken when `cmdReady` is high |
| cmdReady | output | 1 | Engine idle and able to take a command |
| cmdOp | input | 2 | 1 complete, 2 sync, 3 notify control, 0 none |
| cmdQueue | input | QW | Queue number |
| cmdId | input | 32 | Head identifier for a completion |
| cmdLen | input | 32 | Total length for a completion |
| cmdEnable | input | 1 | Notify control: 1 enables notifications (clears no-notify) |
| usedBaseFlat | input | NUM_QUEUES*AW | Used ring word base per queue, queue q at bits q*AW |
| availBaseFlat | input | NUM_QUEUES*AW | Available ring word base per queue |
| queueEmpty | input | NUM_QUEUES | Per-queue drained indication |
| notifyOnEmpty | input | 1 | Notify-on-empty feature negotiated |
| memWrEn | output | 1 | Memory write strobe |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | AW | Word address |
| memWrData | output | 32 | Write data |
| memByteEn | output | 4 | Byte enables for writes |
| memRdData | input | 32 | Read data, valid the cycle after `memRdEn` |
| isrRdEn | input | 1 | Read-and-clear of the cause register |
| isrValue | output | 8 | Cause register |
| irqLine | output | 1 | Level interrupt |
| countRaised | output | CNT_W | Interrupts raised |
| countSkipped | output | CNT_W | Interrupts suppressed |

## Verification
Producer indices are not visible at the ports. A wrong index therefore shows up as a used element in the wrong slot on the very next completion, or as a wrong published value at the next sync, which the bench compares against its own per-queue index model. A bad interrupt decision shows up within the same sync command: a wrong cause bit, line level or counter step appears as soon as `cmdReady` returns. A bad read-modify-write shows up as a changed neighbouring flag bit or a changed index half-word. Busy-time commands are checked by snapshotting the slot they would have hit and then confirming where the next real completion lands.

// File: rtl/ucomp_pkg.sv
package ucomp_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_COMPLETE = 2'd1,
    OP_SYNC     = 2'd2,
    OP_NOTIFY   = 2'd3
  } opKind_t;

  // Strobes from the sequencer to the datapath, one per action.
  typedef struct packed {
    logic latchCmd;
    logic wrId;
    logic wrLen;
    logic wrIdx;
    logic rdAvail;
    logic capAvail;
    logic rdUsed;
    logic capUsed;
    logic wrFlags;
    logic raise;
    logic skip;
  } ctlStrobe_t;

endpackage

// File: rtl/ucomp_ctrl.sv
module ucomp_ctrl
  import ucomp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       wantIrq,
  output logic       cmdReady,
  output ctlStrobe_t stb
);

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_LEN, S_IDX, S_RDA, S_WTA, S_DEC, S_RDU, S_WTU, S_WRF
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    cmdReady  = 1'b0;
    unique case (state)
      S_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid && (opKind_t'(cmdOp) != OP_NONE)) begin
          stb.latchCmd = 1'b1;
          unique case (opKind_t'(cmdOp))
            OP_COMPLETE: nextState = S_ID;
            OP_SYNC:     nextState = S_IDX;
            default:     nextState = S_RDU;
          endcase
        end
      end
      S_ID:  begin stb.wrId     = 1'b1; nextState = S_LEN;  end
      S_LEN: begin stb.wrLen    = 1'b1; nextState = S_IDLE; end
      S_IDX: begin stb.wrIdx    = 1'b1; nextState = S_RDA;  end
      S_RDA: begin stb.rdAvail  = 1'b1; nextState = S_WTA;  end
      S_WTA: begin stb.capAvail = 1'b1; nextState = S_DEC;  end
      S_DEC: begin
        stb.raise = wantIrq;
        stb.skip  = !wantIrq;
        nextState = S_IDLE;
      end
      S_RDU: begin stb.rdUsed   = 1'b1; nextState = S_WTU;  end
      S_WTU: begin stb.capUsed  = 1'b1; nextState = S_WRF;  end
      S_WRF: begin stb.wrFlags  = 1'b1; nextState = S_IDLE; end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/ucomp_dp.sv
module ucomp_dp
  import ucomp_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int RING_LOG2  = 3,
  parameter int AW         = 12,
  parameter int CNT_W      = 16,
  localparam int QW        = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               stb,
  input  logic [QW-1:0]            cmdQueue,
  input  logic [31:0]              cmdId,
  input  logic [31:0]              cmdLen,
  input  logic                     cmdEnable,
  input  logic [NUM_QUEUES*AW-1:0] usedBaseFlat,
  input  logic [NUM_QUEUES*AW-1:0] availBaseFlat,
  input  logic [NUM_QUEUES-1:0]    queueEmpty,
  input  logic                     notifyOnEmpty,
  input  logic [31:0]              memRdData,
  input  logic                     isrRdEn,
  output logic                     memWrEn,
  output logic                     memRdEn,
  output logic [AW-1:0]            memAddr,
  output logic [31:0]              memWrData,
  output logic [3:0]               memByteEn,
  output logic                     wantIrq,
  output logic [7:0]               isrValue,
  output logic                     irqLine,
  output logic [CNT_W-1:0]         countRaised,
  output logic [CNT_W-1:0]         countSkipped
);

  localparam int IDX_W = 16;
  localparam logic [7:0] QUEUE_CAUSE = 8'h01;

  logic [QW-1:0]               qSel;
  logic [31:0]                 idReg, lenReg, rdWord;
  logic                        enReg;
  logic [NUM_QUEUES*IDX_W-1:0] idxVec;

  // Per-queue producer index.
  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
    logic [IDX_W-1:0] prodIdx;
    always_ff @(posedge clk) begin
      if (!rstN)                                prodIdx <= '0;
      else if (stb.wrLen && (qSel == QW'(q)))   prodIdx <= prodIdx + 1'b1;
    end
    assign idxVec[q*IDX_W +: IDX_W] = prodIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qSel   <= '0;
      idReg  <= '0;
      lenReg <= '0;
      enReg  <= 1'b0;
      rdWord <= '0;
    end else begin
      if (stb.latchCmd) begin
        qSel   <= cmdQueue;
        idReg  <= cmdId;
        lenReg <= cmdLen;
        enReg  <= cmdEnable;
      end
      if (stb.capAvail || stb.capUsed) rdWord <= memRdData;
    end
  end

  logic [IDX_W-1:0]     curIdx;
  logic [RING_LOG2-1:0] slot;
  logic [AW-1:0]        usedBase, availBase, elemAddr;

  assign curIdx    = idxVec[qSel*IDX_W +: IDX_W];
  assign slot      = curIdx[RING_LOG2-1:0];
  assign usedBase  = usedBaseFlat[qSel*AW +: AW];
  assign availBase = availBaseFlat[qSel*AW +: AW];
  assign elemAddr  = usedBase + AW'(1) + (AW'(slot) << 1);

  always_comb begin
    memWrEn   = 1'b0;
    memRdEn   = 1'b0;
    memAddr   = '0;
    memWrData = '0;
    memByteEn = 4'b0000;
    if (stb.wrId) begin
      memWrEn = 1'b1; memAddr = elemAddr;          memWrData = idReg;  memByteEn = 4'b1111;
    end else if (stb.wrLen) begin
      memWrEn = 1'b1; memAddr = elemAddr + AW'(1); memWrData = lenReg; memByteEn = 4'b1111;
    end else if (stb.wrIdx) begin
      memWrEn = 1'b1; memAddr = usedBase; memWrData = {curIdx, 16'h0000}; memByteEn = 4'b1100;
    end else if (stb.rdAvail) begin
      memRdEn = 1'b1; memAddr = availBase;
    end else if (stb.rdUsed) begin
      memRdEn = 1'b1; memAddr = usedBase;
    end else if (stb.wrFlags) begin
      memWrEn   = 1'b1;
      memAddr   = usedBase;
      memWrData = {16'h0000, rdWord[15:1], ~enReg};
      memByteEn = 4'b0011;
    end
  end

  // Interrupt gate: driver flag, overridden by notify-on-empty when drained.
  assign wantIrq = !rdWord[0] || (notifyOnEmpty && queueEmpty[qSel]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isrValue     <= '0;
      irqLine      <= 1'b0;
      countRaised  <= '0;
      countSkipped <= '0;
    end else begin
      isrValue <= (isrRdEn ? 8'h00 : isrValue) | (stb.raise ? QUEUE_CAUSE : 8'h00);
      if (stb.raise)    irqLine <= 1'b1;
      else if (isrRdEn) irqLine <= 1'b0;
      if (stb.raise) countRaised  <= countRaised + 1'b1;
      if (stb.skip)  countSkipped <= countSkipped + 1'b1;
    end
  end

endmodule

// File: rtl/used_ring_completer.sv
module used_ring_completer
  import ucomp_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int RING_LOG2  = 3,
  parameter int AW         = 12,
  parameter int CNT_W      = 16,
  localparam int QW        = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  output logic                     cmdReady,
  input  logic [1:0]               cmdOp,
  input  logic [QW-1:0]            cmdQueue,
  input  logic [31:0]              cmdId,
  input  logic [31:0]              cmdLen,
  input  logic                     cmdEnable,
  input  logic [NUM_QUEUES*AW-1:0] usedBaseFlat,
  input  logic [NUM_QUEUES*AW-1:0] availBaseFlat,
  input  logic [NUM_QUEUES-1:0]    queueEmpty,
  input  logic                     notifyOnEmpty,
  output logic                     memWrEn,
  output logic                     memRdEn,
  output logic [AW-1:0]            memAddr,
  output logic [31:0]              memWrData,
  output logic [3:0]               memByteEn,
  input  logic [31:0]              memRdData,
  input  logic                     isrRdEn,
  output logic [7:0]               isrValue,
  output logic                     irqLine,
  output logic [CNT_W-1:0]         countRaised,
  output logic [CNT_W-1:0]         countSkipped
);

  ctlStrobe_t stb;
  logic       wantIrq;

  ucomp_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .wantIrq  (wantIrq),
    .cmdReady (cmdReady),
    .stb      (stb)
  );

  ucomp_dp #(
    .NUM_QUEUES (NUM_QUEUES),
    .RING_LOG2  (RING_LOG2),
    .AW         (AW),
    .CNT_W      (CNT_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .cmdQueue      (cmdQueue),
    .cmdId         (cmdId),
    .cmdLen        (cmdLen),
    .cmdEnable     (cmdEnable),
    .usedBaseFlat  (usedBaseFlat),
    .availBaseFlat (availBaseFlat),
    .queueEmpty    (queueEmpty),
    .notifyOnEmpty (notifyOnEmpty),
    .memRdData     (memRdData),
    .isrRdEn       (isrRdEn),
    .memWrEn       (memWrEn),
    .memRdEn       (memRdEn),
    .memAddr       (memAddr),
    .memWrData     (memWrData),
    .memByteEn     (memByteEn),
    .wantIrq       (wantIrq),
    .isrValue      (isrValue),
    .irqLine       (irqLine),
    .countRaised   (countRaised),
    .countSkipped  (countSkipped)
  );

endmodule

// File: rtl/used_ring_completer_chk.sv
module used_ring_completer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [1:0]       cmdOp,
  input logic             memWrEn,
  input logic             memRdEn,
  input logic [3:0]       memByteEn,
  input logic [7:0]       isrValue,
  input logic             irqLine,
  input logic [CNT_W-1:0] countRaised,
  input logic [CNT_W-1:0] countSkipped
);

  // R1: the memory port never reads and writes at once, and a write carries byte enables
  p_port_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));
  p_write_has_bytes_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memByteEn != 4'b0000));

  // R4: a new cause bit comes with exactly one raised count
  p_raise_counted_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isrValue[0]) |-> (countRaised == $past(countRaised) + 1'b1));

  // R5: the skipped count moves by at most one per cycle
  p_skip_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (countSkipped == $past(countSkipped)) || (countSkipped == $past(countSkipped) + 1'b1));

  // R6: one sync yields one outcome only
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rstN)
    !((countRaised != $past(countRaised)) && (countSkipped != $past(countSkipped))));

  // R8: the line level follows the cause register, and only the queue cause bit is used
  p_line_follows_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqLine == (isrValue != 8'h00));
  p_cause_bit_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    isrValue[7:1] == 7'h00);

  // R9: an accepted command makes the engine busy on the next cycle
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && (cmdOp != 2'd0)) |=> !cmdReady);

endmodule

bind used_ring_completer used_ring_completer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cmdValid     (cmdValid),
  .cmdReady     (cmdReady),
  .cmdOp        (cmdOp),
  .memWrEn      (memWrEn),
  .memRdEn      (memRdEn),
  .memByteEn    (memByteEn),
  .isrValue     (isrValue),
  .irqLine      (irqLine),
  .countRaised  (countRaised),
  .countSkipped (countSkipped)
);

// File: tb/test_used_ring_completer.sv
module test_used_ring_completer;

  localparam int CLK_PERIOD = 10;
  localparam int NQ    = 4;
  localparam int RLOG  = 3;
  localparam int RSIZE = 1 << RLOG;
  localparam int AW    = 12;
  localparam int CW    = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [1:0]        cmdOp = 2'd0;
  logic [1:0]        cmdQueue = '0;
  logic [31:0]       cmdId = '0, cmdLen = '0;
  logic              cmdEnable = 1'b0;
  logic [NQ*AW-1:0]  usedBaseFlat, availBaseFlat;
  logic [NQ-1:0]     queueEmpty = '0;
  logic              notifyOnEmpty = 1'b0;
  logic              memWrEn, memRdEn;
  logic [AW-1:0]     memAddr;
  logic [31:0]       memWrData;
  logic [3:0]        memByteEn;
  logic [31:0]       memRdData;
  logic              isrRdEn = 1'b0;
  logic [7:0]        isrValue;
  logic              irqLine;
  logic [CW-1:0]     countRaised, countSkipped;

  logic [31:0] mem [0:(1<<AW)-1];
  logic          tbWrEn = 1'b0;
  logic [AW-1:0] tbWrAddr = '0;
  logic [31:0]   tbWrData = '0;

  int total = 0, bad = 0;
  int expIdx [NQ];
  int pubIdx [NQ];
  int expIsr = 0, expRaised = 0, expSkipped = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar q = 0; q < NQ; q++) begin : g_base
    assign usedBaseFlat[q*AW +: AW]  = AW'(q*256 + 128);
    assign availBaseFlat[q*AW +: AW] = AW'(q*256);
  end

  used_ring_completer #(.NUM_QUEUES(NQ), .RING_LOG2(RLOG), .AW(AW), .CNT_W(CW)) i_used_ring_completer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdQueue(cmdQueue), .cmdId(cmdId), .cmdLen(cmdLen), .cmdEnable(cmdEnable),
    .usedBaseFlat(usedBaseFlat), .availBaseFlat(availBaseFlat), .queueEmpty(queueEmpty),
    .notifyOnEmpty(notifyOnEmpty), .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memWrData(memWrData), .memByteEn(memByteEn), .memRdData(memRdData), .isrRdEn(isrRdEn),
    .isrValue(isrValue), .irqLine(irqLine), .countRaised(countRaised), .countSkipped(countSkipped)
  );

  // Memory model: byte-enabled writes, one-cycle read latency.
  always @(posedge clk) begin
    if (tbWrEn) mem[tbWrAddr] <= tbWrData;
    else if (memWrEn) begin
      for (int b = 0; b < 4; b++)
        if (memByteEn[b]) mem[memAddr][b*8 +: 8] <= memWrData[b*8 +: 8];
    end
    if (memRdEn) memRdData <= mem[memAddr];
  end

  function automatic int usedB(int q);  return q*256 + 128; endfunction
  function automatic int availB(int q); return q*256;       endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic setMem(int addr, logic [31:0] data);
    @(negedge clk);
    tbWrEn = 1'b1; tbWrAddr = AW'(addr); tbWrData = data;
    @(negedge clk);
    tbWrEn = 1'b0;
  endtask

  task automatic doCmd(int op, int q, logic [31:0] id, logic [31:0] len, bit en);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdQueue = 2'(q);
    cmdId = id; cmdLen = len; cmdEnable = en;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
    while (!cmdReady) @(negedge clk);
  endtask

  task automatic complete(int q, logic [31:0] id, logic [31:0] len);
    int s = expIdx[q] % RSIZE;
    doCmd(1, q, id, len, 1'b0);
    chk("R2 id word", mem[usedB(q) + 1 + 2*s], id);
    chk("R2 len word", mem[usedB(q) + 2 + 2*s], len);
    chk("R3 index untouched by completion", {16'h0, mem[usedB(q)][31:16]}, 32'(pubIdx[q]));
    expIdx[q] = (expIdx[q] + 1) & 16'hFFFF;
  endtask

  task automatic sync(int q, bit noInt, bit noe, logic [NQ-1:0] empt);
    bit want;
    logic [15:0] upper = 16'($urandom) & 16'hFFFE;
    setMem(availB(q), {16'h0, upper | 16'(noInt)});
    @(negedge clk);
    notifyOnEmpty = noe; queueEmpty = empt;
    doCmd(2, q, '0, '0, 1'b0);
    pubIdx[q] = expIdx[q];
    chk("R3 published index", {16'h0, mem[usedB(q)][31:16]}, 32'(pubIdx[q]));
    want = !noInt || (noe && empt[q]);
    if (want) begin expIsr = 1; expRaised++; end
    else expSkipped++;
    chk(want ? (noInt ? "R6 override raise" : "R4 raise cause") : "R5 suppressed cause",
        {24'h0, isrValue}, 32'(expIsr));
    chk(want ? "R4 line" : "R5 line", {31'h0, irqLine}, 32'(expIsr != 0));
    chk("R4 raised count", {16'h0, countRaised}, 32'(expRaised & 16'hFFFF));
    chk("R5 skipped count", {16'h0, countSkipped}, 32'(expSkipped & 16'hFFFF));
  endtask

  task automatic notifyCtl(int q, bit en);
    logic [15:0] flg = 16'($urandom);
    setMem(usedB(q), {16'(pubIdx[q]), flg});
    doCmd(3, q, '0, '0, en);
    chk("R7 flags rewrite", {16'h0, mem[usedB(q)][15:0]}, {16'h0, flg[15:1], ~en});
    chk("R7 index half kept", {16'h0, mem[usedB(q)][31:16]}, 32'(pubIdx[q]));
  endtask

  task automatic readIsr();
    @(negedge clk);
    isrRdEn = 1'b1;
    #1 chk("R8 read value", {24'h0, isrValue}, 32'(expIsr));
    @(negedge clk);
    isrRdEn = 1'b0;
    expIsr = 0;
    chk("R8 cleared", {24'h0, isrValue}, 32'h0);
    chk("R8 line low", {31'h0, irqLine}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    logic [31:0] snap;
    void'($urandom(32'h5eed_0007));
    for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
    for (int q = 0; q < NQ; q++) begin expIdx[q] = 0; pubIdx[q] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'h0, cmdReady}, 32'h1);
    chk("R1 line", {31'h0, irqLine}, 32'h0);
    chk("R1 cause", {24'h0, isrValue}, 32'h0);
    chk("R1 counts", {countRaised, countSkipped}, 32'h0);
    chk("R1 port idle", {30'h0, memWrEn, memRdEn}, 32'h0);

    // Directed: slot wrap on queue 1 (R2)
    for (int i = 0; i < RSIZE + 2; i++) complete(1, 32'h1000 + 32'(i), 32'h20 + 32'(i));
    sync(1, 1'b0, 1'b0, '0);          // R4
    readIsr();                         // R8
    sync(1, 1'b1, 1'b0, 4'b1111);     // R5 (no override without feature)
    sync(1, 1'b1, 1'b1, 4'b0010);     // R6 override
    sync(1, 1'b1, 1'b1, 4'b1101);     // R6 other queues empty only: skip
    readIsr();
    notifyCtl(2, 1'b0);                // R7 set no-notify
    notifyCtl(2, 1'b1);                // R7 clear no-notify

    // R9: command during busy is ignored
    snap = mem[usedB(2) + 1 + 2*(expIdx[2] % RSIZE)];
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd2; cmdQueue = 2'd0;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd1; cmdQueue = 2'd2; cmdId = 32'hDEAD_BEEF; cmdLen = 32'h55;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
    while (!cmdReady) @(negedge clk);
    pubIdx[0] = expIdx[0];
    if (isrValue != 0) begin expIsr = 1; expRaised++; end else expSkipped++;
    chk("R9 busy command ignored", mem[usedB(2) + 1 + 2*(expIdx[2] % RSIZE)], snap);
    complete(2, 32'hCAFE_0001, 32'h77);  // lands at unadvanced slot (R9)

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 3));
      int q  = int'($urandom_range(0, NQ-1));
      case (op)
        0: complete(q, $urandom, $urandom);
        1: sync(q, 1'($urandom), 1'($urandom), 4'($urandom));
        2: notifyCtl(q, 1'($urandom));
        default: readIsr();
      endcase
    end

    finished = 1'b1;
    report();
  end

endmodule